// File: doc/BRIEF.md
# Instruction Cycle Controller

This block sequences a 16-bit machine that has one accumulator. It holds the program counter, the address register, the instruction register, the data register and the accumulator. For every instruction it steps through fetch, decode, an optional indirect-address step, an optional operand read and execute. It keeps doing this until it executes a halt operation. Each step drives one source onto the internal bus. It also issues per-register load, increment and clear strobes and the memory read and write strobes. Every memory access uses the address register.

An instruction word uses bit 15 as the addressing-mode flag and bits 14..12 as the opcode. Bits 11..0 hold either a memory address or a bit-coded operation field. Opcode 7 with mode 0 is a register operation, and opcode 7 with mode 1 is an I/O operation. Any other opcode is a memory operation, and mode 1 then adds one memory read that fetches the effective address. Memory is external and asynchronous-read: `mem_rdata` must show the word at `mem_addr` within the same cycle.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: A synchronous `rst` sets PC, AC, AR, IR and DR to zero, `phase` to 0 (first fetch step) and `halted` to 0. This also applies when the controller is halted.
- R2: Fetch takes two cycles. Phase 0 drives PC on the bus (`bus_sel`=2) and loads AR. Phase 1 asserts `mem_rd`, loads IR from memory and increments PC in the same clock.
- R3: The phases are coded 0 fetch-address, 1 fetch-word, 2 decode, 3 indirect, 4 operand read, 5 execute, 6 halted. Decode always loads AR from IR bits 11..0. A register or I/O instruction then goes to execute. A memory instruction goes to indirect when bit 15 is 1. Otherwise it goes to operand read, or straight to execute for opcodes 3 and 4.
- R4: The indirect phase asserts `mem_rd` and loads AR with bits 11..0 of the word that AR addresses.
- R5: In execute, the memory opcodes are: 0 AC&=M, 1 AC+=M (mod 2^16), 2 AC=M, 3 M=AC, 4 PC=AR (jump), 5 AC^=M, 6 skip the next instruction when AC equals M. Every opcode except 3 and 4 has M read in the operand-read phase.
- R6: `mem_wr` is high only in the execute cycle of opcode 3. In that cycle `bus_sel` is 4 and `mem_wdata` equals AC.
- R7: A register operation acts on AC through field bits with this priority: bit 11 clears AC, else bit 10 complements AC, else bit 9 increments AC.
- R8: A register operation with bit 8 set skips the next instruction when AC was zero before that instruction executes.
- R9: A register operation with bit 0 set enters phase 6. There `halted` is 1, and PC and AC stay unchanged with no memory access until reset.
- R10: An I/O operation pulses `io_strobe` for its single execute cycle and leaves AC and PC unchanged.
- R11: `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Word at `mem_addr` |
| mem_addr | output | 12 | Memory address (AR) |
| mem_wdata | output | 16 | Bus value, written when `mem_wr` |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_strobe | output | 1 | I/O operation execute pulse |
| bus_sel | output | 3 | Bus source: 0 none, 1 AR, 2 PC, 3 DR, 4 AC, 5 IR, 7 memory |
| reg_ld | output | 5 | Load strobes {AC,DR,IR,AR,PC} |
| reg_inc | output | 5 | Increment strobes, same order |
| reg_clr | output | 5 | Clear strobes, same order |
| halted | output | 1 | Halt phase reached |
| phase | output | 3 | Current phase code (R3) |
| pc | output | 12 | Program counter |
| ac | output | 16 | Accumulator |
| ir | output | 16 | Instruction register |

## Verification
Every strobe and `bus_sel` is a combinational function of the current phase and IR. So `mem_rd`, `mem_wr` and `io_strobe` are due in the same cycle as the phase that owns them. Each register change is visible one edge after that phase: PC one edge after phase 1, AR one edge after decode or indirect, AC one edge after execute. The bench runs a reference model that takes the same clock edge as the design. It compares phase, PC, AC, AR and the strobes at every falling edge, half a cycle after the edge that produced them. Final register and memory values, and the set of fetched addresses, are checked once the halt phase is reached.

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          io_strobe,
  output logic [2:0]    bus_sel,
  output logic [4:0]    reg_ld,
  output logic [4:0]    reg_inc,
  output logic [4:0]    reg_clr,
  output logic          halted,
  output logic [2:0]    phase,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] ac,
  output logic [DW-1:0] ir
);
  localparam int RPC = 0, RAR = 1, RIR = 2, RDR = 3, RAC = 4;

  typedef enum logic [2:0] {
    S_F0 = 3'd0, S_F1 = 3'd1, S_DEC = 3'd2, S_IND = 3'd3,
    S_RD = 3'd4, S_EXE = 3'd5, S_HLT = 3'd6
  } st_t;

  st_t st, nxt;
  logic [AW-1:0] pc_q, ar_q;
  logic [DW-1:0] ir_q, dr_q, ac_q, bus, alu;
  logic [4:0] ld, inc, clr;
  logic [2:0] sel;

  wire [2:0] opc     = ir_q[DW-2:DW-4];
  wire       mode    = ir_q[DW-1];
  wire       is_mem  = opc != 3'b111;
  wire       is_io   = !is_mem && mode;
  wire       no_read = opc == 3'd3 || opc == 3'd4;
  wire       ac_zero = ac_q == '0;

  always_comb begin
    ld = '0; inc = '0; clr = '0; sel = 3'd0; nxt = st; alu = ac_q;
    case (st)
      S_F0: begin sel = 3'd2; ld[RAR] = 1'b1; nxt = S_F1; end
      S_F1: begin sel = 3'd7; ld[RIR] = 1'b1; inc[RPC] = 1'b1; nxt = S_DEC; end
      S_DEC: begin
        sel = 3'd5; ld[RAR] = 1'b1;
        if (!is_mem)      nxt = S_EXE;
        else if (mode)    nxt = S_IND;
        else if (no_read) nxt = S_EXE;
        else              nxt = S_RD;
      end
      S_IND: begin sel = 3'd7; ld[RAR] = 1'b1; nxt = no_read ? S_EXE : S_RD; end
      S_RD:  begin sel = 3'd7; ld[RDR] = 1'b1; nxt = S_EXE; end
      S_EXE: begin
        nxt = S_F0;
        if (is_mem) begin
          case (opc)
            3'd0: begin ld[RAC] = 1'b1; alu = ac_q & dr_q; end
            3'd1: begin ld[RAC] = 1'b1; alu = ac_q + dr_q; end
            3'd2: begin ld[RAC] = 1'b1; alu = dr_q; end
            3'd3: sel = 3'd4;
            3'd4: begin sel = 3'd1; ld[RPC] = 1'b1; end
            3'd5: begin ld[RAC] = 1'b1; alu = ac_q ^ dr_q; end
            default: inc[RPC] = (ac_q == dr_q);
          endcase
        end else if (!mode) begin
          if (ir_q[AW-1])      clr[RAC] = 1'b1;
          else if (ir_q[AW-2]) begin ld[RAC] = 1'b1; alu = ~ac_q; end
          else if (ir_q[AW-3]) inc[RAC] = 1'b1;
          if (ir_q[AW-4] && ac_zero) inc[RPC] = 1'b1;
          if (ir_q[0]) nxt = S_HLT;
        end
      end
      default: nxt = S_HLT;
    endcase
  end

  always_comb begin
    case (sel)
      3'd1:    bus = DW'(ar_q);
      3'd2:    bus = DW'(pc_q);
      3'd3:    bus = dr_q;
      3'd4:    bus = ac_q;
      3'd5:    bus = ir_q;
      3'd7:    bus = mem_rdata;
      default: bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_F0;
      pc_q <= '0; ar_q <= '0; ir_q <= '0; dr_q <= '0; ac_q <= '0;
    end else begin
      st <= nxt;
      if (clr[RPC])      pc_q <= '0;
      else if (ld[RPC])  pc_q <= bus[AW-1:0];
      else if (inc[RPC]) pc_q <= pc_q + 1'b1;
      if (clr[RAR])      ar_q <= '0;
      else if (ld[RAR])  ar_q <= bus[AW-1:0];
      else if (inc[RAR]) ar_q <= ar_q + 1'b1;
      if (clr[RIR])      ir_q <= '0;
      else if (ld[RIR])  ir_q <= bus;
      if (clr[RDR])      dr_q <= '0;
      else if (ld[RDR])  dr_q <= bus;
      else if (inc[RDR]) dr_q <= dr_q + 1'b1;
      if (clr[RAC])      ac_q <= '0;
      else if (ld[RAC])  ac_q <= alu;
      else if (inc[RAC]) ac_q <= ac_q + 1'b1;
    end
  end

  assign mem_addr  = ar_q;
  assign mem_wdata = bus;
  assign mem_rd    = sel == 3'd7;
  assign mem_wr    = st == S_EXE && is_mem && opc == 3'd3;
  assign io_strobe = st == S_EXE && is_io;
  assign halted    = st == S_HLT;
  assign bus_sel   = sel;
  assign reg_ld    = ld;
  assign reg_inc   = inc;
  assign reg_clr   = clr;
  assign phase     = st;
  assign pc        = pc_q;
  assign ac        = ac_q;
  assign ir        = ir_q;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (st == S_F0 && pc_q == '0 && ac_q == '0));
  a_r2_fetch_step: assert property (@(posedge clk) disable iff (rst)
    st == S_F1 |=> pc_q == AW'($past(pc_q) + 1'b1));
  a_r4_indirect_addr: assert property (@(posedge clk) disable iff (rst)
    st == S_IND |=> (st == S_RD || st == S_EXE) && ar_q == $past(mem_rdata[AW-1:0]));
  a_r6_write_exec: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (st == S_EXE && bus_sel == 3'd4 && mem_wdata == ac_q));
  a_r9_halt_hold: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc_q) && $stable(ac_q) && !mem_rd);
  a_r11_rw_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

// File: tb/instr_cycle_ctrl_test.sv
module instr_cycle_ctrl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] mem_rdata, mem_wdata, ac, ir;
  logic [11:0] mem_addr, pc;
  logic mem_rd, mem_wr, io_strobe, halted;
  logic [2:0] bus_sel, phase;
  logic [4:0] reg_ld, reg_inc, reg_clr;
  logic [15:0] mem [0:4095];
  logic [4095:0] fetched;
  int checks = 0, errors = 0, io_count = 0;
  int m_st, m_pc, m_ar, m_ir, m_dr, m_ac, op, ind, old_ac, fld;
  bit done = 0;

  always #5 clk = ~clk;
  assign mem_rdata = mem[mem_addr];

  instr_cycle_ctrl uut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .io_strobe(io_strobe), .bus_sel(bus_sel), .reg_ld(reg_ld),
    .reg_inc(reg_inc), .reg_clr(reg_clr), .halted(halted), .phase(phase),
    .pc(pc), .ac(ac), .ir(ir)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on the same edge as the design
  always @(posedge clk) begin
    op = (m_ir >> 12) & 7;
    ind = (m_ir >> 15) & 1;
    if (rst) begin
      m_st = 0; m_pc = 0; m_ar = 0; m_ir = 0; m_dr = 0; m_ac = 0;
    end else begin
      case (m_st)
        0: begin m_ar = m_pc; m_st = 1; end
        1: begin m_ir = mem[m_ar]; m_pc = (m_pc + 1) % 4096; m_st = 2; end
        2: begin
          m_ar = m_ir & 12'hFFF;
          if (op == 7) m_st = 5;
          else if (ind == 1) m_st = 3;
          else m_st = (op == 3 || op == 4) ? 5 : 4;
        end
        3: begin m_ar = mem[m_ar] & 12'hFFF; m_st = (op == 3 || op == 4) ? 5 : 4; end
        4: begin m_dr = mem[m_ar]; m_st = 5; end
        5: begin
          m_st = 0;
          if (op != 7) begin
            case (op)
              0: m_ac = m_ac & m_dr;
              1: m_ac = (m_ac + m_dr) & 16'hFFFF;
              2: m_ac = m_dr;
              3: mem[m_ar] = m_ac[15:0];
              4: m_pc = m_ar;
              5: m_ac = m_ac ^ m_dr;
              default: if (m_ac == m_dr) m_pc = (m_pc + 1) % 4096;
            endcase
          end else if (ind == 0) begin
            fld = m_ir & 12'hFFF;
            old_ac = m_ac;
            if (fld & 12'h800) m_ac = 0;
            else if (fld & 12'h400) m_ac = ~m_ac & 16'hFFFF;
            else if (fld & 12'h200) m_ac = (m_ac + 1) & 16'hFFFF;
            if ((fld & 12'h100) != 0 && old_ac == 0) m_pc = (m_pc + 1) % 4096;
            if (fld & 1) m_st = 6;
          end
        end
        default: m_st = 6;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      op = (m_ir >> 12) & 7;
      ind = (m_ir >> 15) & 1;
      chk("R3 phase", 32'(phase), m_st);
      chk("R2 pc", 32'(pc), m_pc);
      chk("R5 ac", 32'(ac), m_ac);
      chk("R4 addr", 32'(mem_addr), m_ar);
      chk("R2 mem_rd", 32'(mem_rd), (m_st == 1 || m_st == 3 || m_st == 4));
      chk("R6 mem_wr", 32'(mem_wr), (m_st == 5 && op == 3));
      chk("R10 io_strobe", 32'(io_strobe), (m_st == 5 && op == 7 && ind == 1));
      chk("R9 halted", 32'(halted), (m_st == 6));
      chk("R11 rd/wr", 32'(mem_rd & mem_wr), 0);
      if (mem_wr) chk("R6 wdata", 32'(mem_wdata), m_ac);
      if (phase == 3'd0 && !halted) chk("R2 bus_sel", 32'(bus_sel), 2);
      if (phase == 3'd2) fetched[pc - 12'd1] = 1'b1;
      if (io_strobe) io_count++;
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
    fetched = '0;
  endtask

  task automatic run_to_halt();
    for (int i = 0; i < 3000 && !halted; i++) @(negedge clk);
    chk("R9 reached halt", 32'(halted), 1);
    repeat (10) @(negedge clk);
    chk("R9 still halted", 32'(halted), 1);
  endtask

  task automatic reset_check();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pc", 32'(pc), 0);
    chk("R1 ac", 32'(ac), 0);
    chk("R1 phase", 32'(phase), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 ir", 32'(ir), 0);
  endtask

  initial begin
    clear_mem();
    mem[12'h000] = 16'h2100; // load direct
    mem[12'h001] = 16'h9101; // add indirect
    mem[12'h002] = 16'h3103; // store direct
    mem[12'h003] = 16'h5100; // xor
    mem[12'h004] = 16'h6104; // skip if equal
    mem[12'h005] = 16'h7200; // skipped
    mem[12'h006] = 16'h0105; // and
    mem[12'h007] = 16'hF040; // i/o
    mem[12'h008] = 16'hC106; // jump indirect
    mem[12'h009] = 16'h7001; // never fetched
    mem[12'h00A] = 16'h7400; // complement
    mem[12'h00B] = 16'h7100; // skip-if-zero, not taken
    mem[12'h00C] = 16'h7800; // clear
    mem[12'h00D] = 16'h7100; // skip-if-zero, taken
    mem[12'h00E] = 16'h7200; // skipped
    mem[12'h00F] = 16'h7001; // halt
    mem[12'h100] = 16'h00F0;
    mem[12'h101] = 16'h0102;
    mem[12'h102] = 16'h0005;
    mem[12'h104] = 16'h0005;
    mem[12'h105] = 16'h0F0F;
    mem[12'h106] = 16'h000A;
    reset_check();
    @(negedge clk); rst = 1'b0;
    run_to_halt();
    chk("R7 final ac A", 32'(ac), 0);
    chk("R9 final pc A", 32'(pc), 12'h010);
    chk("R6 stored word", 32'(mem[12'h103]), 16'h00F5);
    chk("R8 seq skipped 5", 32'(fetched[5]), 0);
    chk("R8 sza skipped E", 32'(fetched[14]), 0);
    chk("R8 sza not taken B", 32'(fetched[12]), 1);
    chk("R5 jump skipped 9", 32'(fetched[9]), 0);
    chk("R10 io pulses A", io_count, 1);

    reset_check();
    clear_mem();
    io_count = 0;
    mem[12'h000] = 16'h7800; // clear
    mem[12'h001] = 16'h7200; // inc
    mem[12'h002] = 16'h7200; // inc
    mem[12'h003] = 16'hB107; // store indirect
    mem[12'h004] = 16'hF001; // i/o with bit 0 set: no halt
    mem[12'h005] = 16'h7201; // inc and halt
    mem[12'h107] = 16'h0120;
    @(negedge clk); rst = 1'b0;
    run_to_halt();
    chk("R7 final ac B", 32'(ac), 3);
    chk("R9 final pc B", 32'(pc), 6);
    chk("R4 indirect store", 32'(mem[12'h120]), 2);
    chk("R10 io pulses B", io_count, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual timeout expected halt");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule